// File: doc/BRIEF.md
# UART Register Front End with Interrupt Requests

This block is the register face of a simple UART. A host reaches four word-aligned registers through a single-cycle bus port. The registers are a character register, a status-flag register, a control register and an interrupt-identification register. Behind them sit a one-entry receive holding register and a transmit path with no storage. Two level interrupt lines, one for receive and one for transmit, go to an external interrupt controller.

Received characters arrive on a byte stream that uses valid/ready. The block raises `rx_ready` only when the holding register contains zero and no receive interrupt is pending. A character transfers on a clock edge where both `rx_valid` and `rx_ready` are high. When `rx_ready` is low the block does not take the byte. The source may keep `rx_data` on the stream or drop it, and the block never latches it later. Outgoing characters leave as a one-cycle `tx_valid` pulse that carries `tx_data`. This output has no ready input, so the sink must take every pulse.

Bus reads are combinational. `bus_rdata` reflects the register state before the clock edge, and any side effect of the read happens on that edge. Reading the character register empties it, which hands the receiver back to the stream.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the character register is 0, the flag register reads 0x80 (only bit 7 set), the control and identification registers read 0, and `rx_irq`, `tx_irq` and `tx_valid` are low.
- R2: A character transfers when `rx_valid` and `rx_ready` are both high. On the next cycle the character register holds it, flag bit 4 (receive-empty) reads 0, identification bit 1 (receive status) reads 1 and `rx_irq` is high.
- R3: `rx_ready` is high exactly when `rx_irq` is low and the character register holds zero. A byte offered while it is low leaves the character register, the flags and `rx_irq` unchanged.
- R4: A bus read of offset 0x00 returns the held character in bits 7:0 with the upper bits zero. It then clears the character register, sets flag bit 4, clears identification bit 1 and drops `rx_irq`.
- R5: If a read of offset 0x00 and a character transfer happen on the same edge, the read returns the old value and the new character wins. The register holds the new byte, flag bit 4 is 0, identification bit 1 is 1 and `rx_irq` is high.
- R6: A bus write to offset 0x00 produces `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits 7:0 of the written word. In every other cycle `tx_valid` is low.
- R7: A write to offset 0x14 stores bits 7:0 as the control register. If bit 5 (transmit interrupt enable) is 1, `tx_irq` goes high and identification bit 2 is set. If it is 0, `tx_irq` goes low and identification bit 2 is cleared. `tx_irq` changes on no other event.
- R8: A write to offset 0x1C replaces the identification register with bits 7:0 of the word, and it leaves `rx_irq` and `tx_irq` unchanged. A transfer on the same edge still sets bit 1.
- R9: Reads of any offset other than 0x00, 0x14, 0x18 and 0x1C return 0. Writes to those offsets, and to the read-only flag offset 0x18, change nothing.
- R10: Flag bit 7 (transmit-empty) always reads 1, and every other flag bit except bit 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| rx_valid | input | 1 | Receive stream byte offered |
| rx_ready | output | 1 | Receive stream can take a byte |
| rx_data | input | CHAR_W | Receive stream byte |
| tx_valid | output | 1 | One-cycle transmit pulse |
| tx_data | output | CHAR_W | Transmit byte |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The properties assume that bus inputs and stream inputs are stable around the sampling edge and hold no X or Z values. They do not assume that a source waits for `rx_ready`, so the stimulus offers bytes both while the holding register is busy and while it is free. The bus port carries at most one access per cycle. The stimulus therefore mixes single reads and writes across the implemented offsets, the flag offset and unused offsets, and it lines up character-register reads with stream transfers to reach the tie case.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
  localparam int unsigned OFS_DATA  = 32'h00;
  localparam int unsigned OFS_CTRL  = 32'h14;
  localparam int unsigned OFS_FLAG  = 32'h18;
  localparam int unsigned OFS_IDENT = 32'h1C;

  localparam int unsigned FLG_TXE  = 7;
  localparam int unsigned FLG_RXE  = 4;
  localparam int unsigned IDF_RX   = 1;
  localparam int unsigned IDF_TX   = 2;
  localparam int unsigned CTL_TXIE = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_FLAG,
    SEL_CTRL,
    SEL_IDENT
  } reg_sel_e;
endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
  import uart_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel_o,
  output logic              rd_data_o,
  output logic              wr_data_o,
  output logic              wr_ctrl_o,
  output logic              wr_ident_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_DATA))       sel_o = SEL_DATA;
    else if (bus_addr == ADDR_W'(OFS_FLAG))  sel_o = SEL_FLAG;
    else if (bus_addr == ADDR_W'(OFS_CTRL))  sel_o = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_IDENT)) sel_o = SEL_IDENT;
  end

  assign rd_data_o  = bus_sel && !bus_wr && (sel_o == SEL_DATA);
  assign wr_data_o  = bus_sel &&  bus_wr && (sel_o == SEL_DATA);
  assign wr_ctrl_o  = bus_sel &&  bus_wr && (sel_o == SEL_CTRL);
  assign wr_ident_o = bus_sel &&  bus_wr && (sel_o == SEL_IDENT);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              take_i,
  output logic              accept_o,
  output logic [CHAR_W-1:0] hold_q,
  output logic              rxe_q,
  output logic              irq_q
);
  assign rx_ready = !irq_q && (hold_q == '0);
  assign accept_o = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rxe_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (accept_o) begin
      hold_q <= rx_data;
      rxe_q  <= 1'b0;
      irq_q  <= 1'b1;
    end else if (take_i) begin
      hold_q <= '0;
      rxe_q  <= 1'b1;
      irq_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_ctrl_irq.sv
module uart_ctrl_irq
  import uart_front_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_ident_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic              take_i,
  output logic [CHAR_W-1:0] ctrl_q,
  output logic [CHAR_W-1:0] ident_q,
  output logic              tx_irq_q
);
  logic [CHAR_W-1:0] ident_d;

  always_comb begin
    ident_d = ident_q;
    if (wr_ident_i) ident_d = wdata_i;
    if (wr_ctrl_i)  ident_d[IDF_TX] = wdata_i[CTL_TXIE];
    if (take_i)     ident_d[IDF_RX] = 1'b0;
    if (accept_i)   ident_d[IDF_RX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ident_q  <= '0;
      tx_irq_q <= 1'b0;
    end else begin
      ident_q <= ident_d;
      if (wr_ctrl_i) begin
        ctrl_q   <= wdata_i;
        tx_irq_q <= wdata_i[CTL_TXIE];
      end
    end
  end
endmodule

// File: rtl/uart_tx_emit.sv
module uart_tx_emit #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_i;
      if (wr_i) tx_data <= wdata_i;
    end
  end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              rx_irq,
  output logic              tx_irq
);
  reg_sel_e          sel;
  logic              rd_data, wr_data, wr_ctrl, wr_ident;
  logic              accept;
  logic [CHAR_W-1:0] hold_q, ctrl_q, ident_q, flag_w;
  logic              rxe_q;
  logic [CHAR_W-1:0] wchar;

  assign wchar = bus_wdata[CHAR_W-1:0];

  uart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .sel_o     (sel),
    .rd_data_o (rd_data),
    .wr_data_o (wr_data),
    .wr_ctrl_o (wr_ctrl),
    .wr_ident_o(wr_ident)
  );

  uart_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_ready(rx_ready),
    .take_i  (rd_data),
    .accept_o(accept),
    .hold_q  (hold_q),
    .rxe_q   (rxe_q),
    .irq_q   (rx_irq)
  );

  uart_ctrl_irq #(.CHAR_W(CHAR_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .wr_ident_i(wr_ident),
    .wdata_i   (wchar),
    .accept_i  (accept),
    .take_i    (rd_data),
    .ctrl_q    (ctrl_q),
    .ident_q   (ident_q),
    .tx_irq_q  (tx_irq)
  );

  uart_tx_emit #(.CHAR_W(CHAR_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_data),
    .wdata_i (wchar),
    .tx_valid(tx_valid),
    .tx_data (tx_data)
  );

  always_comb begin
    flag_w          = '0;
    flag_w[FLG_TXE] = 1'b1;
    flag_w[FLG_RXE] = rxe_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (sel)
        SEL_DATA:  bus_rdata = DATA_W'(hold_q);
        SEL_FLAG:  bus_rdata = DATA_W'(flag_w);
        SEL_CTRL:  bus_rdata = DATA_W'(ctrl_q);
        SEL_IDENT: bus_rdata = DATA_W'(ident_q);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_data,
  input logic              rx_irq,
  input logic              tx_irq
);
  logic a_data, a_flag, a_ctrl, a_ident, a_other;
  assign a_data  = bus_addr == ADDR_W'(32'h00);
  assign a_ctrl  = bus_addr == ADDR_W'(32'h14);
  assign a_flag  = bus_addr == ADDR_W'(32'h18);
  assign a_ident = bus_addr == ADDR_W'(32'h1C);
  assign a_other = !(a_data || a_ctrl || a_flag || a_ident);

  // R2
  rx_take_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> rx_irq);
  // R3
  rx_irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !(bus_sel && !bus_wr && a_data) |=> rx_irq);
  // R3
  rx_ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !rx_ready);
  // R4
  rx_read_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && a_data && !(rx_valid && rx_ready) |=> !rx_irq);
  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && a_data |=> tx_valid && tx_data == $past(bus_wdata[CHAR_W-1:0]));
  // R6
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && a_data) |=> !tx_valid);
  // R7
  tx_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && a_ctrl && bus_wdata[5] |=> tx_irq);
  // R7
  tx_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && a_ctrl && !bus_wdata[5] |=> !tx_irq);
  // R7
  tx_irq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && a_ctrl) |=> $stable(tx_irq));
  // R9
  unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && a_other |-> bus_rdata == '0);
  // R10
  flag_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && a_flag |-> bus_rdata[7] && (bus_rdata & ~DATA_W'(32'h90)) == '0);
endmodule

bind uart_reg_front uart_reg_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
);

// File: tb/uart_reg_front_bench.sv
`timescale 1ns/1ps
module uart_reg_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, rx_irq, tx_irq;
  logic [7:0]  tx_data;

  always #2 clk = ~clk;

  uart_reg_front u_uart_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  int total = 0, bad = 0;
  bit model_on = 1'b0;
  int m_dr = 0, m_rxe = 0, m_cr = 0, m_iir = 0, m_rxirq = 0, m_txirq = 0;
  int m_txv = 0, m_txd = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      'h00: return m_dr;
      'h18: return 'h80 | (m_rxe << 4);
      'h14: return m_cr;
      'h1C: return m_iir;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    case (a)
      'h00: return "R4 data read";
      'h18: return "R10 flag read";
      'h14: return "R7 control read";
      'h1C: return "R8 ident read";
      default: return "R9 unused read";
    endcase
  endfunction

  // behavioural reference, updated on every edge after reset
  always @(posedge clk) begin
    if (model_on) begin
      int acc, rd, wr;
      acc = (rx_valid && m_rxirq == 0 && m_dr == 0) ? 1 : 0;
      rd  = (bus_sel && !bus_wr && bus_addr == 8'h00) ? 1 : 0;
      wr  = (bus_sel && bus_wr) ? 1 : 0;
      m_txv = 0;
      if (rd != 0) begin
        m_dr = 0; m_rxe = 1; m_iir = m_iir & ~2; m_rxirq = 0;
      end
      if (wr != 0) begin
        case (int'(bus_addr))
          'h00: begin m_txv = 1; m_txd = int'(bus_wdata[7:0]); end
          'h14: begin
            m_cr = int'(bus_wdata[7:0]);
            if (bus_wdata[5]) begin m_txirq = 1; m_iir = m_iir | 4; end
            else begin m_txirq = 0; m_iir = m_iir & ~4; end
          end
          'h1C: m_iir = int'(bus_wdata[7:0]);
          default: ;
        endcase
      end
      if (acc != 0) begin
        m_dr = int'(rx_data); m_rxe = 0; m_iir = m_iir | 2; m_rxirq = 1;
      end
    end
  end

  task automatic cyc(input bit s, input bit w, input int a, input int d,
                     input bit rv, input int rd_byte);
    @(negedge clk);
    chk("R2 rx_irq", int'(rx_irq), m_rxirq);
    chk("R7 tx_irq", int'(tx_irq), m_txirq);
    chk("R6 tx_valid", int'(tx_valid), m_txv);
    if (m_txv != 0) chk("R6 tx_data", int'(tx_data), m_txd);
    bus_sel = s; bus_wr = w; bus_addr = 8'(a); bus_wdata = 32'(d);
    rx_valid = rv; rx_data = 8'(rd_byte);
    #1;
    chk("R3 rx_ready", int'(rx_ready), (m_rxirq == 0 && m_dr == 0) ? 1 : 0);
    if (s && !w) chk(rd_tag(a), int'(bus_rdata), exp_rd(a));
  endtask

  task automatic rd(input int a);   cyc(1, 0, a, 0, 0, 0); endtask
  task automatic wrt(input int a, input int d); cyc(1, 1, a, d, 0, 0); endtask
  task automatic idle();            cyc(0, 0, 0, 0, 0, 0); endtask

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    // R1 reset state
    rd('h18); chk("R1 flag at reset", int'(bus_rdata), 'h80);
    rd('h00); chk("R1 data at reset", int'(bus_rdata), 0);
    rd('h14); chk("R1 control at reset", int'(bus_rdata), 0);
    rd('h1C); chk("R1 ident at reset", int'(bus_rdata), 0);
    chk("R1 irqs and tx at reset", int'({rx_irq, tx_irq, tx_valid}), 0);
    // R5 read and transfer on the same edge
    cyc(1, 0, 'h00, 0, 1, 'h5A); chk("R5 read returns old", int'(bus_rdata), 0);
    rd('h18); chk("R5 receive-empty low", int'(bus_rdata), 'h80);
    chk("R5 rx_irq high", int'(rx_irq), 1);
    // R3 byte offered while busy is ignored
    cyc(0, 0, 0, 0, 1, 'h33);
    rd('h00); chk("R3 held byte kept", int'(bus_rdata), 'h5A);
    rd('h18); chk("R4 receive-empty set", int'(bus_rdata), 'h90);
    rd('h1C); chk("R4 ident bit1 clear", int'(bus_rdata), 0);
    chk("R4 rx_irq low", int'(rx_irq), 0);
    // R2 plain transfer
    cyc(0, 0, 0, 0, 1, 'hC4);
    rd('h1C); chk("R2 ident bit1 set", int'(bus_rdata), 2);
    rd('h00); chk("R2 byte stored", int'(bus_rdata), 'hC4);
    // R6 transmit pulse
    wrt('h00, 'h123456A7);
    idle(); chk("R6 pulse", int'(tx_valid), 1); chk("R6 byte", int'(tx_data), 'hA7);
    idle(); chk("R6 single cycle", int'(tx_valid), 0);
    // R7 control
    wrt('h14, 'h20);
    rd('h1C); chk("R7 ident bit2 set", int'(bus_rdata), 4);
    chk("R7 tx_irq high", int'(tx_irq), 1);
    wrt('h14, 'h0F);
    rd('h14); chk("R7 control stored", int'(bus_rdata), 'h0F);
    chk("R7 tx_irq low", int'(tx_irq), 0);
    // R8 identification overwrite
    wrt('h1C, 'hFFC3);
    rd('h1C); chk("R8 ident written", int'(bus_rdata), 'hC3);
    chk("R8 lines unchanged", int'({rx_irq, tx_irq}), 0);
    // R9 unused offsets and read-only flags
    wrt('h04, 'hFF);
    rd('h04); chk("R9 unused reads zero", int'(bus_rdata), 0);
    wrt('h18, 0);
    rd('h18); chk("R9 flag write ignored", int'(bus_rdata), 'h90);
    // mixed traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      int pick, addrs[6];
      addrs = '{'h00, 'h14, 'h18, 'h1C, 'h04, 'h24};
      pick = int'($urandom_range(0, 5));
      cyc(($urandom_range(0, 2) != 0), $urandom_range(0, 1) == 1, addrs[pick],
          int'($urandom), $urandom_range(0, 1) == 1, int'($urandom_range(0, 255)));
    end
    idle();
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule